// File: doc/BRIEF.md
# Weak Connected-Component Labeling Engine

This block gives every vertex of a small graph, held in on-chip storage, the identifier of its weakly connected component. Two adjacency structures are loaded through one write port before a run. The forward structure lists the edges leaving each vertex. The reverse structure lists the edges entering each vertex. Each structure is an offset table of NV+1 entries and a neighbour table of NE entries. The neighbours of vertex u occupy the neighbour-table slots from offset[u] up to, but not including, offset[u+1].

A start pulse clears every label and seeds vertex 0 as the first root. A breadth-first walk, driven by a single FIFO of vertex ids, then visits each popped vertex's neighbours through both structures. An unvisited neighbour takes the label of the vertex it was reached from and is queued. When the queue drains, the engine scans upward from the last root for the next unvisited vertex and starts a new walk from it. Because roots are found in ascending order, every component ends up labelled with its lowest vertex id. Once a scan reaches the end without finding an unvisited vertex, done rises and the labels stay readable through a combinational read port until the next start.

Top module: `cc_label_engine`

## Requirements
- R1: After reset, done is low and every vertex reads back the unvisited sentinel (all ones on rd_label).
- R2: A start pulse accepted while idle or done makes done read low on the following cycle. done rises again when labelling completes.
- R3: After completion, each vertex's label equals the lowest vertex id in its weakly connected component.
- R4: A vertex with no incident edges is labelled with its own id.
- R5: An edge found only while scanning the reverse structure (an edge from a higher id to a lower id) still joins both vertices into one component.
- R6: Load writes (ld_en) arriving while a run is in progress are ignored and do not change the graph used by that run.
- R7: After done rises, done and all labels hold until the next start. A later start with a newly loaded graph recomputes the labels.
- R8: The load select code is 0 for forward offsets, 1 for forward neighbours, 2 for reverse offsets and 3 for reverse neighbours. ld_addr is the table entry index.
- R9: The queue never overflows or underflows, even when one vertex discovers every other vertex at once. Discovery stalls instead of dropping a vertex if the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one graph table entry |
| ld_sel | input | 2 | Table select (see R8) |
| ld_addr | input | AW | Entry index within the selected table |
| ld_data | input | DW | Entry value (offset or neighbour id) |
| start | input | 1 | Begin a labelling run |
| done | output | 1 | Labelling finished; labels valid |
| rd_addr | input | VW | Vertex whose label is read |
| rd_label | output | VW+1 | Label of rd_addr; all ones means unvisited |

## Verification
A corrupted queue pointer or count shows up as a vertex that is labelled twice or never. The result is a wrong label at readback, or done never rising, which the run-length limit catches within a few thousand cycles. A broken reverse-structure walk only shows on graphs whose edges point from high ids to low ids, so those graphs are exercised on purpose. A faulty root scan gives an isolated or later component a label that is not its minimum. Writes accepted during a busy run appear as labels computed from a damaged graph in the same run.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POP,
        ST_EDGE,
        ST_SCAN,
        ST_DONE
    } cc_state_e;
endpackage

// File: rtl/cc_queue.sv
module cc_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } qctl_t;

    qctl_t        q_d, q_q;
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    assign head  = mem_q[q_q.rd];
    assign empty = (q_q.cnt == '0);
    assign full  = (q_q.cnt == CAP);

    always_comb begin
        q_d   = q_q;
        mem_d = mem_q;
        if (push && !full) begin
            mem_d[q_q.wr] = push_data;
            q_d.wr = (q_q.wr == LAST) ? '0 : q_q.wr + PW'(1);
        end
        if (pop && !empty) begin
            q_d.rd = (q_q.rd == LAST) ? '0 : q_q.rd + PW'(1);
        end
        q_d.cnt = q_q.cnt + CW'(push && !full) - CW'(pop && !empty);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            q_q   <= q_d;
            mem_q <= mem_d;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/cc_adj_store.sv
module cc_adj_store #(
    parameter int NV = 16,
    parameter int NE = 32,
    parameter int VW = 4,
    parameter int EW = 6,
    parameter int AW = 6,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_off,
    input  logic          wr_nbr,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [VW-1:0] vtx,
    output logic [EW-1:0] off_lo,
    output logic [EW-1:0] off_hi,
    input  logic [EW-1:0] slot,
    output logic [VW-1:0] nbr
);
    logic [EW-1:0] off_d [NV+1];
    logic [EW-1:0] off_q [NV+1];
    logic [VW-1:0] nb_d  [NE];
    logic [VW-1:0] nb_q  [NE];

    always_comb begin
        off_d = off_q;
        nb_d  = nb_q;
        if (wr_off && int'(wr_addr) <= NV) off_d[wr_addr] = wr_data[EW-1:0];
        if (wr_nbr && int'(wr_addr) <  NE) nb_d[wr_addr]  = wr_data[VW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= NV; i++) off_q[i] <= '0;
            for (int i = 0; i < NE; i++)  nb_q[i]  <= '0;
        end else begin
            off_q <= off_d;
            nb_q  <= nb_d;
        end
    end

    assign off_lo = off_q[vtx];
    assign off_hi = off_q[{1'b0, vtx} + (VW+1)'(1)];
    assign nbr    = (int'(slot) < NE) ? nb_q[slot] : '0;
endmodule

// File: rtl/cc_label_engine.sv
module cc_label_engine
    import cc_pkg::*;
#(
    parameter int NV = 16,
    parameter int NE = 32,
    parameter int VW = $clog2(NV),
    parameter int EW = $clog2(NE + 1),
    parameter int AW = (VW + 1 > EW) ? VW + 1 : EW,
    parameter int DW = (EW > VW) ? EW : VW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [1:0]    ld_sel,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          start,
    output logic          done,
    input  logic [VW-1:0] rd_addr,
    output logic [VW:0]   rd_label
);
    localparam int LW = VW + 1;
    localparam logic [LW-1:0] SENT = '1;
    localparam logic [VW:0]   NVL  = (VW+1)'(NV);
    localparam logic [EW-1:0] NEL  = EW'(NE);

    typedef struct packed {
        cc_state_e     st;
        logic [VW-1:0] cur;
        logic          dir;
        logic [EW-1:0] ptr;
        logic [EW-1:0] lim;
        logic [VW:0]   scan;
    } ctl_t;

    ctl_t          c_d, c_q;
    logic [LW-1:0] lab_d [NV];
    logic [LW-1:0] lab_q [NV];

    logic          q_push, q_pop, q_empty, q_full;
    logic [VW-1:0] q_in, q_head;
    logic          discover;
    logic          idle;
    logic [VW-1:0] mem_vtx;
    logic [EW-1:0] off_lo [2];
    logic [EW-1:0] off_hi [2];
    logic [VW-1:0] nbr    [2];
    logic [VW-1:0] nsel;

    assign idle    = (c_q.st == ST_IDLE) || (c_q.st == ST_DONE);
    assign mem_vtx = (c_q.st == ST_POP) ? q_head : c_q.cur;
    assign nsel    = nbr[c_q.dir];

    for (genvar g = 0; g < 2; g++) begin : g_adj
        cc_adj_store #(.NV(NV), .NE(NE), .VW(VW), .EW(EW), .AW(AW), .DW(DW)) u_adj (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_off  (ld_en && idle && (ld_sel[1] == 1'(g)) && !ld_sel[0]),
            .wr_nbr  (ld_en && idle && (ld_sel[1] == 1'(g)) &&  ld_sel[0]),
            .wr_addr (ld_addr),
            .wr_data (ld_data),
            .vtx     (mem_vtx),
            .off_lo  (off_lo[g]),
            .off_hi  (off_hi[g]),
            .slot    (c_q.ptr),
            .nbr     (nbr[g])
        );
    end

    cc_queue #(.DEPTH(NV), .W(VW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_in),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    always_comb begin
        c_d      = c_q;
        lab_d    = lab_q;
        q_push   = 1'b0;
        q_pop    = 1'b0;
        q_in     = '0;
        discover = 1'b0;
        case (c_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    for (int i = 0; i < NV; i++) lab_d[i] = SENT;
                    lab_d[0] = '0;
                    q_push   = 1'b1;
                    c_d.scan = '0;
                    c_d.st   = ST_POP;
                end
            end
            ST_POP: begin
                if (q_empty) begin
                    c_d.st = ST_SCAN;
                end else begin
                    q_pop   = 1'b1;
                    c_d.cur = q_head;
                    c_d.dir = 1'b0;
                    c_d.ptr = off_lo[0];
                    c_d.lim = off_hi[0];
                    c_d.st  = ST_EDGE;
                end
            end
            ST_EDGE: begin
                if (c_q.ptr == c_q.lim || c_q.ptr >= NEL) begin
                    if (!c_q.dir) begin
                        c_d.dir = 1'b1;
                        c_d.ptr = off_lo[1];
                        c_d.lim = off_hi[1];
                    end else begin
                        c_d.st = ST_POP;
                    end
                end else if (lab_q[nsel] != SENT) begin
                    c_d.ptr = c_q.ptr + EW'(1);
                end else if (!q_full) begin
                    discover    = 1'b1;
                    lab_d[nsel] = lab_q[c_q.cur];
                    q_push      = 1'b1;
                    q_in        = nsel;
                    c_d.ptr     = c_q.ptr + EW'(1);
                end
            end
            ST_SCAN: begin
                if (c_q.scan == NVL) begin
                    c_d.st = ST_DONE;
                end else if (lab_q[c_q.scan[VW-1:0]] == SENT) begin
                    lab_d[c_q.scan[VW-1:0]] = {1'b0, c_q.scan[VW-1:0]};
                    q_push = 1'b1;
                    q_in   = c_q.scan[VW-1:0];
                    c_d.st = ST_POP;
                end else begin
                    c_d.scan = c_q.scan + (VW+1)'(1);
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
            for (int i = 0; i < NV; i++) lab_q[i] <= SENT;
        end else begin
            c_q   <= c_d;
            lab_q <= lab_d;
        end
    end

    assign done     = (c_q.st == ST_DONE);
    assign rd_label = lab_q[rd_addr];

    // R2
    start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> !done);
    // R7
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    // R3
    source_labelled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_EDGE) |-> (lab_q[c_q.cur] != SENT));
    // R3
    label_not_above_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discover |-> (lab_q[c_q.cur] <= {1'b0, nsel}));
endmodule

// File: tb/cc_label_engine_bench.sv
module cc_label_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;
    localparam int NE = 32;
    localparam int VW = $clog2(NV);
    localparam int EW = $clog2(NE + 1);
    localparam int AW = (VW + 1 > EW) ? VW + 1 : EW;
    localparam int DW = (EW > VW) ? EW : VW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [1:0]    ld_sel = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic          start = 1'b0;
    logic          done;
    logic [VW-1:0] rd_addr = '0;
    logic [VW:0]   rd_label;

    int n_cmp = 0;
    int n_bad = 0;
    int e_src [NE];
    int e_dst [NE];
    int n_e = 0;
    int expv [NV];
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_label_engine #(.NV(NV), .NE(NE)) u_cc_label_engine (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
        .ld_data(ld_data), .start(start), .done(done), .rd_addr(rd_addr), .rd_label(rd_label)
    );

    task automatic check(input string tag, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic wr(input int sel, input int addr, input int data);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'(sel); ld_addr = AW'(addr); ld_data = DW'(data);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // R8: select 0/1 forward offsets/neighbours, 2/3 reverse offsets/neighbours
    task automatic load_graph();
        for (int d = 0; d < 2; d++) begin
            int pos = 0;
            for (int u = 0; u < NV; u++) begin
                wr(2*d, u, pos);
                for (int k = 0; k < n_e; k++) begin
                    int key = (d == 0) ? e_src[k] : e_dst[k];
                    int oth = (d == 0) ? e_dst[k] : e_src[k];
                    if (key == u) begin
                        wr(2*d + 1, pos, oth);
                        pos++;
                    end
                end
            end
            wr(2*d, NV, pos);
        end
    endtask

    task automatic compute_expected();
        for (int i = 0; i < NV; i++) expv[i] = i;
        for (int r = 0; r < NV; r++)
            for (int k = 0; k < n_e; k++) begin
                int m = (expv[e_src[k]] < expv[e_dst[k]]) ? expv[e_src[k]] : expv[e_dst[k]];
                expv[e_src[k]] = m;
                expv[e_dst[k]] = m;
            end
    endtask

    task automatic pulse_start(input string tag);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check({tag, " R2 done low after start"}, int'(done), 0);
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        check({tag, " R2 done rises"}, int'(done), 1);
    endtask

    task automatic read_all(input string tag);
        for (int v = 0; v < NV; v++) begin
            rd_addr = VW'(v);
            #1;
            check(tag, int'(rd_label), expv[v]);
        end
    endtask

    task automatic t_reset();
        check("R1 done after reset", int'(done), 0);
        for (int i = 0; i < NV; i++) expv[i] = (1 << (VW + 1)) - 1;
        read_all("R1 sentinel");
    endtask

    task automatic t_mixed();
        n_e = 5;
        e_src[0] = 0;  e_dst[0] = 1;
        e_src[1] = 2;  e_dst[1] = 1;
        e_src[2] = 5;  e_dst[2] = 3;
        e_src[3] = 3;  e_dst[3] = 4;
        e_src[4] = 7;  e_dst[4] = 7;
        load_graph(); compute_expected();
        pulse_start("mixed"); wait_done("mixed");
        read_all("R3 mixed components");
    endtask

    task automatic t_weak();
        n_e = 4;
        e_src[0] = 9;  e_dst[0] = 2;
        e_src[1] = 12; e_dst[1] = 9;
        e_src[2] = 15; e_dst[2] = 14;
        e_src[3] = 14; e_dst[3] = 6;
        load_graph(); compute_expected();
        pulse_start("weak"); wait_done("weak");
        read_all("R5 R8 reverse-only reach");
    endtask

    task automatic t_isolated();
        n_e = 0;
        load_graph(); compute_expected();
        pulse_start("iso"); wait_done("iso");
        read_all("R4 isolated self label");
    endtask

    task automatic t_star();
        n_e = NV - 1;
        for (int k = 0; k < NV - 1; k++) begin e_src[k] = k + 1; e_dst[k] = 0; end
        load_graph(); compute_expected();
        pulse_start("star"); wait_done("star");
        read_all("R9 star fills queue");
    endtask

    task automatic t_hold();
        repeat (20) @(negedge clk);
        check("R7 done held", int'(done), 1);
        read_all("R7 labels held");
        n_e = 3;
        e_src[0] = 4;  e_dst[0] = 8;
        e_src[1] = 8;  e_dst[1] = 13;
        e_src[2] = 1;  e_dst[2] = 11;
        load_graph(); compute_expected();
        pulse_start("rerun"); wait_done("rerun");
        read_all("R7 recomputed");
    endtask

    task automatic t_busy_load();
        n_e = NV - 1;
        for (int k = 0; k < NV - 1; k++) begin e_src[k] = k; e_dst[k] = k + 1; end
        load_graph(); compute_expected();
        pulse_start("busy");
        for (int u = 0; u < 4; u++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_sel = 2'd0; ld_addr = AW'(u + 1); ld_data = '0;
        end
        @(negedge clk); ld_en = 1'b0;
        wait_done("busy");
        read_all("R6 busy writes ignored");
        pulse_start("busy2"); wait_done("busy2");
        read_all("R6 graph intact");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                n_cmp++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mixed();
        t_weak();
        t_isolated();
        t_star();
        t_hold();
        t_busy_load();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule